// File: doc/BRIEF.md
# SMBus Bus-Timeout Reset Monitor

This block watches the clock and data lines of a two-wire system management bus. It produces a one-cycle reset for the slave interface's protocol state machine when the bus master asks for a reset purely through timing. There are two such timing requests. The first is too much total clock-low time inside a single transaction. The second is the clock line held high for too long without a break. Both lines are brought into the local clock domain through two-flop synchronisers. A transaction is opened by a Start condition and closed by a Stop condition, and the monitor decodes only these two conditions.

The low-time measure adds up every clock-low phase between a Start and the following Stop. It does not clear when the clock goes high again. The Stop clears it, and clock-low time outside a transaction is not counted. The high-time measure counts one continuous high period and restarts on every falling clock edge. Each threshold is given in milliseconds and turned into a cycle count with a clock-frequency parameter given in kHz. Both counters saturate, so each event produces one reset pulse. Two sticky flags record which timeout fired. A clear input drops both flags.

Top module: `smb_idle_reset_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `slave_rst_o`, `low_to_flag_o` and `high_to_flag_o` are 0 until a timeout occurs.
- R2: Both lines pass through two-flop synchronisers. A Start is an SDA fall while SCL is high, and a Stop is an SDA rise while SCL is high. An SDA change while SCL is low opens or closes nothing.
- R3: SCL-low time outside a Start-to-Stop window is not counted, and it never causes a reset.
- R4: Inside a window, SCL-low cycles add up over all low phases. Returning SCL high does not clear the sum.
- R5: A reset fires when the sum reaches LOW_LIMIT = CLK_KHZ*LOW_MS cycles. A sum of LOW_LIMIT-1 cycles fires nothing.
- R6: A Stop clears the accumulated low time, so two transactions each under the limit fire nothing.
- R7: A reset fires when SCL has been high continuously for HIGH_LIMIT = CLK_KHZ*HIGH_MS cycles. HIGH_LIMIT-1 cycles fires nothing.
- R8: Every SCL falling edge restarts the continuous-high count.
- R9: Both counters saturate, so one timeout event gives exactly one pulse, however long the condition lasts.
- R10: `slave_rst_o` is high for exactly one clock cycle per event.
- R11: `low_to_flag_o` or `high_to_flag_o` (1 = that timeout fired) is set together with the pulse. It stays set until a cycle with `clr_flags_i` = 1 clears it on the next edge.
- R12: The low-time and high-time timeouts never fire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| clr_flags_i | input | 1 | Clears both sticky flags |
| slave_rst_o | output | 1 | One-cycle reset for the slave state machine |
| low_to_flag_o | output | 1 | Sticky: cumulative low-time timeout fired |
| high_to_flag_o | output | 1 | Sticky: continuous high-time timeout fired |

## Verification
The assertions assume that the synchronised SCL has one level in each cycle, so the two accumulations can never run together. They also assume that Start and Stop never coincide, because SDA cannot rise and fall in the same cycle. The flag properties assume that `clr_flags_i` comes from the same clock domain. The bench drives every input one half period away from the sampling edge. Inside a transaction it holds SDA steady while SCL is high, except for the intended Start and Stop. Outside the high-timeout tests it keeps every idle or high stretch well under the high limit, so no stray pulse can hide the expected one.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

  // Events decoded from the synchronised bus lines.
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_fall;
  } bus_evt_t;

  // Width needed to hold 0..limit inclusive.
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/smbto_sync.sv
module smbto_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_i[g]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= {STAGES{RST_VAL}};
      end else begin
        chain_q <= chain_d;
      end
    end

    assign q_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/smbto_bus_events.sv
module smbto_bus_events (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output smbto_pkg::bus_evt_t evt_o,
  output logic                busy_o
);

  logic scl_q;
  logic sda_q;
  logic busy_q;
  logic busy_d;
  smbto_pkg::bus_evt_t evt;

  always_comb begin
    evt.start    = scl_i & scl_q & sda_q & ~sda_i;
    evt.stop     = scl_i & scl_q & ~sda_q & sda_i;
    evt.scl_fall = scl_q & ~scl_i;
    busy_d       = busy_q;
    if (evt.stop) begin
      busy_d = 1'b0;
    end else if (evt.start) begin
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_q  <= scl_i;
      sda_q  <= sda_i;
      busy_q <= busy_d;
    end
  end

  assign evt_o  = evt;
  assign busy_o = busy_q;

endmodule

// File: rtl/smbto_timer.sv
module smbto_timer #(
  parameter int unsigned LIMIT = 1000,
  parameter int unsigned W     = smbto_pkg::cnt_bits(LIMIT)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         fire_o
);

  localparam logic [W-1:0] LIM    = W'(LIMIT);
  localparam logic [W-1:0] LIM_M1 = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = en_i & (cnt_q != LIM);
    fire_o = en_i & ~clr_i & (cnt_q == LIM_M1);
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/smb_idle_reset_monitor.sv
module smb_idle_reset_monitor #(
  parameter int unsigned CLK_KHZ = 125000,
  parameter int unsigned LOW_MS  = 25,
  parameter int unsigned HIGH_MS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic clr_flags_i,
  output logic slave_rst_o,
  output logic low_to_flag_o,
  output logic high_to_flag_o
);

  localparam int unsigned LOW_LIMIT  = CLK_KHZ * LOW_MS;
  localparam int unsigned HIGH_LIMIT = CLK_KHZ * HIGH_MS;
  localparam int unsigned LOW_W      = smbto_pkg::cnt_bits(LOW_LIMIT);
  localparam int unsigned HIGH_W     = smbto_pkg::cnt_bits(HIGH_LIMIT);

  logic [1:0]          sync_q;
  logic                scl_s;
  logic                sda_s;
  smbto_pkg::bus_evt_t evt;
  logic                busy;
  logic                stop_det;
  logic                scl_fall;
  logic                low_en;
  logic [LOW_W-1:0]    low_cnt;
  logic [HIGH_W-1:0]   high_cnt;
  logic                low_fire;
  logic                high_fire;

  logic pulse_q, pulse_d;
  logic lflag_q, lflag_d;
  logic hflag_q, hflag_d;

  smbto_sync #(
    .WIDTH  (2),
    .STAGES (2),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sda_i, scl_i}),
    .q_o   (sync_q)
  );

  assign scl_s = sync_q[0];
  assign sda_s = sync_q[1];

  smbto_bus_events u_events (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_s),
    .sda_i (sda_s),
    .evt_o (evt),
    .busy_o(busy)
  );

  assign stop_det = evt.stop;
  assign scl_fall = evt.scl_fall;
  assign low_en   = busy & ~scl_s;

  smbto_timer #(
    .LIMIT(LOW_LIMIT),
    .W    (LOW_W)
  ) u_low_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (stop_det),
    .en_i  (low_en),
    .cnt_o (low_cnt),
    .fire_o(low_fire)
  );

  smbto_timer #(
    .LIMIT(HIGH_LIMIT),
    .W    (HIGH_W)
  ) u_high_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (scl_fall),
    .en_i  (scl_s),
    .cnt_o (high_cnt),
    .fire_o(high_fire)
  );

  // A new event wins over a clear arriving in the same cycle.
  always_comb begin
    pulse_d = low_fire | high_fire;
    lflag_d = lflag_q;
    hflag_d = hflag_q;
    if (clr_flags_i) begin
      lflag_d = 1'b0;
      hflag_d = 1'b0;
    end
    if (low_fire) begin
      lflag_d = 1'b1;
    end
    if (high_fire) begin
      hflag_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      lflag_q <= 1'b0;
      hflag_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      lflag_q <= lflag_d;
      hflag_q <= hflag_d;
    end
  end

  assign slave_rst_o    = pulse_q;
  assign low_to_flag_o  = lflag_q;
  assign high_to_flag_o = hflag_q;

endmodule

// File: rtl/smbto_checker.sv
module smbto_checker #(
  parameter int unsigned LOW_W  = 8,
  parameter int unsigned HIGH_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_flags_i,
  input logic              slave_rst_o,
  input logic              low_to_flag_o,
  input logic              high_to_flag_o,
  input logic              low_fire,
  input logic              high_fire,
  input logic              stop_det,
  input logic              scl_fall,
  input logic              busy,
  input logic [LOW_W-1:0]  low_cnt,
  input logic [HIGH_W-1:0] high_cnt
);

  a_r10_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_rst_o |=> !slave_rst_o);

  a_r12_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(low_fire && high_fire));

  a_r11_flag_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_rst_o |-> (low_to_flag_o || high_to_flag_o));

  a_r11_low_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_to_flag_o && !clr_flags_i) |=> low_to_flag_o);

  a_r11_high_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (high_to_flag_o && !clr_flags_i) |=> high_to_flag_o);

  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_flags_i |=> ((!low_to_flag_o && !high_to_flag_o) || slave_rst_o));

  a_r6_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (low_cnt == '0));

  a_r8_fall_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall |=> (high_cnt == '0));

  a_r3_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> ((low_cnt == $past(low_cnt)) || (low_cnt == '0)));

endmodule

bind smb_idle_reset_monitor smbto_checker #(
  .LOW_W (LOW_W),
  .HIGH_W(HIGH_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clr_flags_i   (clr_flags_i),
  .slave_rst_o   (slave_rst_o),
  .low_to_flag_o (low_to_flag_o),
  .high_to_flag_o(high_to_flag_o),
  .low_fire      (low_fire),
  .high_fire     (high_fire),
  .stop_det      (stop_det),
  .scl_fall      (scl_fall),
  .busy          (busy),
  .low_cnt       (low_cnt),
  .high_cnt      (high_cnt)
);

// File: tb/test_smb_idle_reset_monitor.sv
module test_smb_idle_reset_monitor;

  localparam int unsigned CLK_KHZ = 8;
  localparam int unsigned LOW_MS  = 25;
  localparam int unsigned HIGH_MS = 50;
  localparam int LOW_LIM  = CLK_KHZ * LOW_MS;   // 200
  localparam int HIGH_LIM = CLK_KHZ * HIGH_MS;  // 400

  // low cycles per phase, high cycles per phase, phases, expected pulses
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{30,  20,  5, 0},   // R4 150 total
    '{30,  20,  5, 0},   // R6 stop cleared previous sum
    '{30,  20, 10, 1},   // R9 300 total, single pulse
    '{199, 20,  1, 0},   // R5 one below limit
    '{200, 20,  1, 1},   // R5 exactly at limit
    '{99,  20,  2, 0},   // R4 198 total
    '{50, 300,  4, 1},   // R4 long high phases keep the sum
    '{40,  20,  3, 0}    // R6 fresh count after saturation
  };

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda, clr;
  logic slave_rst_o, low_to_flag_o, high_to_flag_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  int  pulses = 0;
  int  wide = 0;
  logic prev_p = 1'b0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  smb_idle_reset_monitor #(
    .CLK_KHZ(CLK_KHZ),
    .LOW_MS (LOW_MS),
    .HIGH_MS(HIGH_MS)
  ) i_smb_idle_reset_monitor (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .scl_i         (scl),
    .sda_i         (sda),
    .clr_flags_i   (clr),
    .slave_rst_o   (slave_rst_o),
    .low_to_flag_o (low_to_flag_o),
    .high_to_flag_o(high_to_flag_o)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (slave_rst_o) pulses++;
      if (slave_rst_o && prev_p) wide++;
    end
    prev_p = slave_rst_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    scl = 1'b1; sda = 1'b1; tick(4);
    sda = 1'b0; tick(10);
  endtask

  task automatic bus_stop();
    sda = 1'b1; tick(4);
  endtask

  task automatic clear_flags(input string req);
    clr = 1'b1; tick(1);
    clr = 1'b0; tick(2);
    check(req, "low flag cleared", int'(low_to_flag_o), 0);
    check(req, "high flag cleared", int'(high_to_flag_o), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R0 watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; clr = 1'b0;
    tick(3);
    check("R1", "pulse in reset", int'(slave_rst_o), 0);
    check("R1", "low flag in reset", int'(low_to_flag_o), 0);
    check("R1", "high flag in reset", int'(high_to_flag_o), 0);
    rst_n = 1'b1;
    tick(2);
    check("R1", "pulse after reset", int'(slave_rst_o), 0);
    check("R1", "flags after reset", int'(low_to_flag_o | high_to_flag_o), 0);
    scl = 1'b0; tick(3);
    scl = 1'b1; tick(5);

    // Vector table: one transaction per entry
    for (int v = 0; v < NV; v++) begin
      pulses = 0;
      bus_start();
      for (int p = 0; p < VEC[v][2]; p++) begin
        scl = 1'b0; tick(VEC[v][0]);
        scl = 1'b1; tick(VEC[v][1]);
      end
      bus_stop();
      tick(4);
      check("R5", $sformatf("vector %0d pulses", v), pulses, VEC[v][3]);
      check("R11", $sformatf("vector %0d low flag", v), int'(low_to_flag_o), VEC[v][3]);
      check("R12", $sformatf("vector %0d high flag", v), int'(high_to_flag_o), 0);
      clear_flags("R11");
    end

    // R3: clock low with no open transaction is ignored
    pulses = 0;
    scl = 1'b0; tick(500);
    scl = 1'b1; tick(5);
    check("R3", "idle low pulses", pulses, 0);
    check("R3", "idle low flag", int'(low_to_flag_o), 0);

    // R7: continuous high, one below and at the limit
    pulses = 0;
    scl = 1'b0; tick(3);
    scl = 1'b1; tick(HIGH_LIM - 1);
    scl = 1'b0; tick(6);
    check("R7", "high limit-1 pulses", pulses, 0);
    scl = 1'b1; tick(HIGH_LIM);
    scl = 1'b0; tick(6);
    check("R7", "high limit pulses", pulses, 1);
    check("R11", "high flag set", int'(high_to_flag_o), 1);
    check("R11", "low flag untouched", int'(low_to_flag_o), 0);
    tick(50);
    check("R11", "high flag sticky", int'(high_to_flag_o), 1);
    clear_flags("R11");

    // R8: a falling edge restarts the high count
    pulses = 0;
    scl = 1'b1; tick(300);
    scl = 1'b0; tick(2);
    scl = 1'b1; tick(300);
    scl = 1'b0; tick(6);
    check("R8", "split high pulses", pulses, 0);

    // R9/R10: very long high gives one single-cycle pulse
    pulses = 0;
    wide = 0;
    scl = 1'b1; tick(1000);
    scl = 1'b0; tick(6);
    check("R9", "long high pulses", pulses, 1);
    check("R10", "wide pulses", wide, 0);
    clear_flags("R11");
    scl = 1'b1; tick(5);

    // R2: SDA moving while SCL low keeps the transaction open
    pulses = 0;
    bus_start();
    scl = 1'b0; tick(100);
    sda = 1'b1; tick(10);
    sda = 1'b0; tick(40);
    scl = 1'b1; tick(20);
    scl = 1'b0; tick(60);
    scl = 1'b1; tick(20);
    bus_stop();
    tick(4);
    check("R2", "sda toggle in low phase pulses", pulses, 1);
    check("R2", "sda toggle low flag", int'(low_to_flag_o), 1);
    clear_flags("R11");

    // R2/R6: a real Stop closes the window, later low time is ignored
    pulses = 0;
    bus_start();
    scl = 1'b0; tick(150);
    scl = 1'b1; tick(20);
    bus_stop();
    scl = 1'b0; tick(100);
    scl = 1'b1; tick(5);
    check("R6", "low after stop pulses", pulses, 0);
    check("R10", "no wide pulse overall", wide, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule